// File: doc/BRIEF.md
# Random-Walk Weight Accumulation Pipeline

This block evaluates Monte Carlo random walks for one entry (i, j) of a matrix inverse. Each walk is a chain of visited state indices. The walk is unrolled into a fixed pipeline of `STEPS` identical stages, and each stage handles one step of the walk.

At each step, a stage looks up the row weight of the state just visited and folds it into the running walk weight. The sign of the traversed matrix entry is applied at the same time. When the visited state equals the target column, the stage adds the new weight into the chain's running contribution.

A new chain may enter on every clock cycle. An external generator supplies the visited states and the signs; matrix storage is held elsewhere. Chain contributions leave the pipe in the order the chains entered. Contributions are summed in groups of 2^`LOG2_CHAINS` chains. Each full group produces an averaged estimate, computed with an arithmetic shift. All arithmetic is on signed integers, and every sum and product saturates at its limit.

Top module: `rw_weight_pipe`

## Requirements
- R1: Every chain starts with weight 1. At step t (1..STEPS), the visited state is `in_states[(t-1)*IDXW +: IDXW]` and the sign bit is `in_neg[t-1]`, where 1 means negative. The new weight is ±(previous weight × row weight of the visited state). `out_weight` carries the weight after the last step.
- R2: `out_contrib` is the sum of the step weights taken only at steps whose visited state equals `in_col`. Steps with any other state leave the sum unchanged.
- R3: Each step weight saturates to the signed WW-bit range.
- R4: The chain contribution and the group sum each saturate to the signed AW-bit range, and both are updated after every addition.
- R5: A chain presented with `in_valid` high appears with `out_valid` high exactly STEPS cycles later. Chains presented on consecutive cycles come out on consecutive cycles.
- R6: A cycle with `in_valid` low travels the pipe as a bubble. When `out_valid` is low, `out_weight` and `out_contrib` are zero. Bubbles do not count toward an estimate group.
- R7: After every 2^LOG2_CHAINS valid chain outputs, `est_valid` pulses for one cycle, on the cycle after the last chain of the group. At that pulse, `est_value` equals the saturated group sum shifted arithmetically right by LOG2_CHAINS, rounding toward minus infinity. The group sum then restarts from zero.
- R8: An active-low `rst_n` clears all chains in flight, the partial group and every output. A new group then needs a full set of chains.
- R9: Row weight s is `row_wt[s*WW +: WW]`, a signed value. It is chosen by comparing the step's state index against each entry index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A chain is presented this cycle |
| in_col | input | IDXW | Target column j |
| in_states | input | STEPS*IDXW | Visited state of each step, step 1 in the lowest field |
| in_neg | input | STEPS | Sign of each step, 1 means negative |
| row_wt | input | NSTATE*WW | Row-weight vector, held stable while chains are in flight |
| out_valid | output | 1 | A finished chain is on the outputs |
| out_weight | output | WW | Final walk weight of the chain |
| out_contrib | output | AW | Contribution of the chain to the estimate |
| est_valid | output | 1 | One-cycle estimate strobe |
| est_value | output | AW | Group sum divided by the chain count |

## Verification
The small worked walk is driven first, with weights (8, 6) and a sign flip on the opening step. Its known weights and target-column total separate a correct sign, weight and match path from a stage that accumulates at the wrong step.

Random walks with small weights, mixed with random bubbles, separate correct valid gating and group counting from a design that lets empty slots leak into an estimate. Walks with weights near the WW limit drive both the product clip and the sum clip, including a group total that saturates before the shift.

A reset in the middle of a group shows whether a partial count survives reset.

// File: rtl/rw_weight_pipe.sv
module rw_weight_pipe #(
  parameter int NSTATE      = 4,
  parameter int STEPS       = 4,
  parameter int WW          = 32,
  parameter int AW          = 48,
  parameter int LOG2_CHAINS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [((NSTATE>1)?$clog2(NSTATE):1)-1:0] in_col,
  input  logic [STEPS*((NSTATE>1)?$clog2(NSTATE):1)-1:0] in_states,
  input  logic [STEPS-1:0]         in_neg,
  input  logic [NSTATE*WW-1:0]     row_wt,
  output logic                     out_valid,
  output logic [WW-1:0]            out_weight,
  output logic [AW-1:0]            out_contrib,
  output logic                     est_valid,
  output logic [AW-1:0]            est_value
);
  localparam int IDXW = (NSTATE > 1) ? $clog2(NSTATE) : 1;
  localparam int SW   = STEPS * IDXW;
  localparam int CW   = (LOG2_CHAINS > 0) ? LOG2_CHAINS : 1;
  localparam logic [CW-1:0] LAST = CW'((1 << LOG2_CHAINS) - 1);
  localparam logic signed [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic signed [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};
  localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

  function automatic logic signed [WW-1:0] clip_w(input logic signed [2*WW-1:0] x);
    if (x[2*WW-1:WW-1] == {(WW+1){x[2*WW-1]}}) return x[WW-1:0];
    else if (x[2*WW-1]) return WMIN;
    else return WMAX;
  endfunction

  function automatic logic signed [AW-1:0] clip_a(input logic signed [AW:0] x);
    if (x[AW] == x[AW-1]) return x[AW-1:0];
    else if (x[AW]) return AMIN;
    else return AMAX;
  endfunction

  logic signed [WW-1:0] ewt [NSTATE];
  for (genvar s = 0; s < NSTATE; s++) begin : g_unpack
    assign ewt[s] = row_wt[s*WW +: WW];
  end

  logic                 p_vld [STEPS+1];
  logic [SW-1:0]        p_st  [STEPS+1];
  logic [STEPS-1:0]     p_neg [STEPS+1];
  logic [IDXW-1:0]      p_col [STEPS+1];
  logic signed [WW-1:0] p_w   [STEPS+1];
  logic signed [AW-1:0] p_v   [STEPS+1];

  assign p_vld[0] = in_valid;
  assign p_st[0]  = in_states;
  assign p_neg[0] = in_neg;
  assign p_col[0] = in_col;
  assign p_w[0]   = {{(WW-1){1'b0}}, 1'b1};
  assign p_v[0]   = '0;

  for (genvar g = 0; g < STEPS; g++) begin : g_stage
    logic [IDXW-1:0]        k;
    logic signed [WW-1:0]   sel;
    logic signed [2*WW-1:0] prod;
    logic signed [WW-1:0]   w_n;
    logic signed [AW:0]     sum;
    logic                   hit;

    logic                 r_vld;
    logic [SW-1:0]        r_st;
    logic [STEPS-1:0]     r_neg;
    logic [IDXW-1:0]      r_col;
    logic signed [WW-1:0] r_w;
    logic signed [AW-1:0] r_v;

    assign k = p_st[g][g*IDXW +: IDXW];

    always_comb begin
      sel = '0;
      for (int s = 0; s < NSTATE; s++)
        if (k == IDXW'(s)) sel = ewt[s];
    end

    assign prod = (2*WW)'(p_w[g]) * (2*WW)'(sel);
    assign w_n  = clip_w(p_neg[g][g] ? -prod : prod);
    assign hit  = p_vld[g] && (k == p_col[g]);
    assign sum  = (AW+1)'(p_v[g]) + (AW+1)'(w_n);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_vld <= 1'b0;
        r_st  <= '0;
        r_neg <= '0;
        r_col <= '0;
        r_w   <= '0;
        r_v   <= '0;
      end else begin
        r_vld <= p_vld[g];
        r_st  <= p_st[g];
        r_neg <= p_neg[g];
        r_col <= p_col[g];
        r_w   <= p_vld[g] ? w_n : '0;
        r_v   <= !p_vld[g] ? '0 : (hit ? clip_a(sum) : p_v[g]);
      end
    end

    assign p_vld[g+1] = r_vld;
    assign p_st[g+1]  = r_st;
    assign p_neg[g+1] = r_neg;
    assign p_col[g+1] = r_col;
    assign p_w[g+1]   = r_w;
    assign p_v[g+1]   = r_v;
  end

  assign out_valid   = p_vld[STEPS];
  assign out_weight  = p_w[STEPS];
  assign out_contrib = p_v[STEPS];

  logic signed [AW-1:0] tot;
  logic [CW-1:0]        cnt;
  logic signed [AW:0]   tsum;
  logic signed [AW-1:0] tnext;

  assign tsum  = (AW+1)'(tot) + (AW+1)'(p_v[STEPS]);
  assign tnext = clip_a(tsum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot       <= '0;
      cnt       <= '0;
      est_valid <= 1'b0;
      est_value <= '0;
    end else begin
      est_valid <= 1'b0;
      if (out_valid) begin
        if (cnt == LAST) begin
          est_valid <= 1'b1;
          est_value <= tnext >>> LOG2_CHAINS;
          tot       <= '0;
          cnt       <= '0;
        end else begin
          tot <= tnext;
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rw_weight_pipe_chk.sv
module rw_weight_pipe_chk #(
  parameter int STEPS       = 4,
  parameter int WW          = 32,
  parameter int AW          = 48,
  parameter int LOG2_CHAINS = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [WW-1:0] out_weight,
  input logic [AW-1:0] out_contrib,
  input logic          est_valid
);
  int inflight;
  int outs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= 0;
      outs     <= 0;
    end else begin
      inflight <= inflight + int'(in_valid) - int'(out_valid);
      outs     <= est_valid ? int'(out_valid) : outs + int'(out_valid);
    end
  end

  assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_contrib == '0 && out_weight == '0));

  assert_out_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight > 0);

  assert_inflight_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= STEPS);

  assert_est_after_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> $past(out_valid));

  assert_est_group_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> outs == (1 << LOG2_CHAINS));

  assert_est_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && LOG2_CHAINS > 0) |=> !est_valid);
endmodule

bind rw_weight_pipe rw_weight_pipe_chk #(
  .STEPS(STEPS), .WW(WW), .AW(AW), .LOG2_CHAINS(LOG2_CHAINS)
) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_weight(out_weight), .out_contrib(out_contrib), .est_valid(est_valid)
);

// File: tb/rw_weight_pipe_test.sv
module rw_weight_pipe_test;
  localparam int NST  = 4;
  localparam int ST   = 4;
  localparam int WW   = 16;
  localparam int AW   = 17;
  localparam int LG   = 3;
  localparam int IDXW = 2;
  localparam int SW   = ST * IDXW;
  localparam int NCH  = 1 << LG;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [IDXW-1:0] in_col;
  logic [SW-1:0] in_states;
  logic [ST-1:0] in_neg;
  logic [NST*WW-1:0] row_wt;
  logic out_valid;
  logic [WW-1:0] out_weight;
  logic [AW-1:0] out_contrib;
  logic est_valid;
  logic [AW-1:0] est_value;

  always #5 clk = ~clk;

  rw_weight_pipe #(.NSTATE(NST), .STEPS(ST), .WW(WW), .AW(AW), .LOG2_CHAINS(LG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
    .in_states(in_states), .in_neg(in_neg), .row_wt(row_wt),
    .out_valid(out_valid), .out_weight(out_weight), .out_contrib(out_contrib),
    .est_valid(est_valid), .est_value(est_value)
  );

  int n_chk = 0;
  int n_bad = 0;
  longint ew [NST];
  bit     q_v [$];
  longint q_w [$];
  longint q_c [$];
  longint m_sum;
  int     m_cnt;
  bit     pend;
  longint pend_val;
  bit     done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint clipw(input longint x);
    longint mx = (longint'(1) <<< (WW-1)) - 1;
    if (x > mx) return mx;
    if (x < -mx - 1) return -mx - 1;
    return x;
  endfunction

  function automatic longint clipa(input longint x);
    longint mx = (longint'(1) <<< (AW-1)) - 1;
    if (x > mx) return mx;
    if (x < -mx - 1) return -mx - 1;
    return x;
  endfunction

  function automatic void model(input logic [SW-1:0] st, input logic [ST-1:0] ng,
                                input int col, output longint w, output longint c);
    w = 1;
    c = 0;
    for (int t = 0; t < ST; t++) begin
      int k;
      k = int'(st[t*IDXW +: IDXW]);
      w = w * ew[k];
      if (ng[t]) w = -w;
      w = clipw(w);
      if (k == col) c = clipa(c + w);
    end
  endfunction

  task automatic load_wt();
    for (int s = 0; s < NST; s++) row_wt[s*WW +: WW] = ew[s][WW-1:0];
  endtask

  task automatic tick(input bit v, input logic [SW-1:0] st, input logic [ST-1:0] ng,
                      input int col, input longint xw, input longint xc);
    @(negedge clk);
    chk("R7 est_valid", longint'(est_valid), longint'(pend));
    if (pend) chk("R7 est_value", longint'($signed(est_value)), pend_val);
    pend = 1'b0;
    if (q_v.size() == ST) begin
      bit     v0 = q_v.pop_front();
      longint w0 = q_w.pop_front();
      longint c0 = q_c.pop_front();
      chk("R5 out_valid", longint'(out_valid), longint'(v0));
      if (v0) begin
        chk("R1 R3 out_weight", longint'($signed(out_weight)), w0);
        chk("R2 R4 out_contrib", longint'($signed(out_contrib)), c0);
        m_sum = clipa(m_sum + c0);
        m_cnt++;
        if (m_cnt == NCH) begin
          pend = 1'b1;
          pend_val = m_sum >>> LG;
          m_sum = 0;
          m_cnt = 0;
        end
      end else begin
        chk("R6 bubble weight", longint'($signed(out_weight)), 0);
        chk("R6 bubble contrib", longint'($signed(out_contrib)), 0);
      end
    end
    in_valid  = v;
    in_states = st;
    in_neg    = ng;
    in_col    = IDXW'(col);
    q_v.push_back(v);
    q_w.push_back(v ? xw : 0);
    q_c.push_back(v ? xc : 0);
  endtask

  task automatic rnd_chain(input int bubble_pct);
    logic [SW-1:0] st = SW'($urandom);
    logic [ST-1:0] ng = ST'($urandom);
    int col = int'($urandom_range(NST-1, 0));
    longint w, c;
    bit v = ($urandom_range(99, 0) >= bubble_pct);
    model(st, ng, col, w, c);
    tick(v, st, ng, col, w, c);
  endtask

  task automatic flush();
    for (int n = 0; n < ST; n++) tick(1'b0, SW'($urandom), ST'($urandom), 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    chk("R8 out_valid in reset", longint'(out_valid), 0);
    chk("R8 out_contrib in reset", longint'($signed(out_contrib)), 0);
    chk("R8 est_valid in reset", longint'(est_valid), 0);
    chk("R8 est_value in reset", longint'($signed(est_value)), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    q_v.delete();
    q_w.delete();
    q_c.delete();
    m_sum = 0;
    m_cnt = 0;
    pend = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_col = '0;
    in_states = '0;
    in_neg = '0;
    ew[0] = 8; ew[1] = 6; ew[2] = 1; ew[3] = 1;
    load_wt();
    m_sum = 0;
    m_cnt = 0;
    pend = 1'b0;
    do_reset();

    // R1 R2 R9: worked walk, states 0,1,0,2, first step negative, column 1
    tick(1'b1, {2'd2, 2'd0, 2'd1, 2'd0}, 4'b0001, 1, -384, -48);
    for (int n = 0; n < NCH - 1; n++) rnd_chain(0);
    flush();

    // R1 R2 R6 R7 R9: small random weights, random bubbles
    for (int s = 0; s < NST; s++) ew[s] = longint'($urandom_range(20, 0));
    load_wt();
    for (int n = 0; n < 300; n++) rnd_chain(25);
    flush();

    // R3 R4: walk on a maximum weight, positive then negative
    ew[0] = 32767; ew[1] = 32767; ew[2] = 2; ew[3] = 1;
    load_wt();
    tick(1'b1, {2'd0, 2'd0, 2'd0, 2'd0}, 4'b0000, 0, 32767, 65535);
    tick(1'b1, {2'd0, 2'd0, 2'd0, 2'd0}, 4'b0001, 0, -32768, -65536);
    for (int n = 0; n < 6; n++)
      tick(1'b1, {2'd0, 2'd0, 2'd0, 2'd0}, 4'b0000, 0, 32767, 65535);
    for (int n = 0; n < 120; n++) rnd_chain(10);
    flush();

    // R8: reset in the middle of a group
    ew[0] = 3; ew[1] = 5; ew[2] = 7; ew[3] = 2;
    load_wt();
    for (int n = 0; n < 3; n++) rnd_chain(0);
    do_reset();
    for (int n = 0; n < 2 * NCH; n++) rnd_chain(0);
    flush();
    tick(1'b0, '0, '0, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule